// File: doc/BRIEF.md
# Thermal Print Head Line Driver

This block takes one line of bi-level print data and drives a thermal print head that has no latch of its own. Bytes arrive on a valid/ready stream. Each byte is sent most significant bit first on a serial data pin, with a separate data clock. When the whole line is in the head, a latch pulse moves it into the head's output stage. The heating phase then runs: the strobe groups fire one after another, each for a programmed number of clocks. The active level of every strobe pin follows a polarity input.

The next line may be shifted in while the strobes of the previous line are still firing. Its latch waits until the last group of the previous line has finished, so the data that is heating never changes under a strobe. A `busy` output covers each request until the heating is over. A single-cycle `done` marks the end of the heating for each line.

The line length, the number of strobe groups, the width of the strobe-length field and the latch length are parameters. The defaults are a 1728-dot line, four groups, a 16-bit length field and a four-clock latch.

Top module: `tph_serial_if`

## Requirements
- R1: After reset the pins are idle. `pclk_o`, `plat_o`, `busy_o`, `done_o` and `byte_ready_o` are low, and every strobe pin sits at its inactive level.
- R2: Each line consumes LINE_DOTS/8 bytes. Bits leave on `pdat_o` most significant bit first within each byte, and bytes leave in arrival order. Exactly LINE_DOTS rising edges of `pclk_o` occur per line.
- R3: `pclk_o` is high for exactly one clock at a time. `pdat_o` changes only while `pclk_o` is low, so it is stable during every high phase.
- R4: `plat_o` rises two clocks after the last falling edge of `pclk_o` in a line. It then stays high for LAT_CLKS clocks while `pclk_o` stays low, once per line.
- R5: The strobe groups fire in ascending index order, 0 first. Each group is active for `strb_width_i` clocks, and a width of 0 counts as 1. Group 0 becomes active in the clock right after the last clock of `plat_o`.
- R6: At most one strobe group is active in any clock.
- R7: With `strb_pol_i`=1 an active strobe pin is high and an inactive one low. With `strb_pol_i`=0 the levels are inverted.
- R8: A new line may start and shift while the previous line is heating. Its latch pulse rises one clock after the first clock in which all strobes of the previous line are inactive.
- R9: `busy_o` is high from the clock after a request is accepted until the strobes of the last pending line end. `done_o` is a one-clock pulse in the first clock after each line's last group goes inactive.
- R10: A `start_i` pulse that arrives while a line is still shifting, waiting or latching has no effect. The line in flight keeps its bit count and gets exactly one latch pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to print one line |
| strb_pol_i | input | 1 | Strobe active level: 1 high, 0 low |
| strb_width_i | input | SW_W | Clocks per strobe group (0 means 1) |
| byte_i | input | 8 | Print data byte |
| byte_valid_i | input | 1 | Byte on `byte_i` is valid |
| byte_ready_o | output | 1 | Block accepts the byte this clock |
| pclk_o | output | 1 | Head data clock |
| pdat_o | output | 1 | Head serial data |
| plat_o | output | 1 | Head latch pulse, active high |
| strb_o | output | GROUPS | Strobe group pins |
| busy_o | output | 1 | Line request in progress |
| done_o | output | 1 | One-clock pulse at the end of a line's heating |

## Verification
Results arrive with fixed latency:
- Each data bit is on `pdat_o` before the rising `pclk_o` that carries it, and it is captured at that rise.
- The latch follows two clocks after the last falling data clock.
- Strobe group 0 starts one clock after the latch ends.
- `done_o` and the drop of `busy_o` come in the first clock with all strobes off.

A monitor samples on the falling clock edge and stamps each of these events with a cycle number. Each check then compares the difference between two stamps with the exact offset stated in the requirement, rather than waiting for the event to happen at some later time. The overlap case compares the rise of the second line's latch with the clock in which the first line's strobes ended.

// File: rtl/tph_pkg.sv
package tph_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SHIFT = 2'd1,
    ST_HOLD  = 2'd2,
    ST_LATCH = 2'd3
  } tph_state_e;
endpackage

// File: rtl/tph_shift.sv
module tph_shift #(
  parameter int LINE_DOTS = 1728
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       go_i,
  input  logic [7:0] byte_i,
  input  logic       byte_valid_i,
  output logic       byte_ready_o,
  output logic       pclk_o,
  output logic       pdat_o,
  output logic       line_done_o
);
  localparam int DOT_W = $clog2(LINE_DOTS + 1);

  logic             active_q, ph_q, pclk_q, pdat_q, done_q;
  logic [7:0]       sreg_q;
  logic [3:0]       nbits_q;
  logic [DOT_W-1:0] dots_q;

  assign byte_ready_o = active_q && (nbits_q == 4'd0);
  assign pclk_o       = pclk_q;
  assign pdat_o       = pdat_q;
  assign line_done_o  = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      ph_q     <= 1'b0;
      pclk_q   <= 1'b0;
      pdat_q   <= 1'b0;
      done_q   <= 1'b0;
      sreg_q   <= '0;
      nbits_q  <= '0;
      dots_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !active_q) begin
        active_q <= 1'b1;
        ph_q     <= 1'b0;
        nbits_q  <= '0;
        dots_q   <= '0;
      end else if (active_q) begin
        if (nbits_q == 4'd0) begin
          if (byte_valid_i) begin
            sreg_q  <= byte_i;
            pdat_q  <= byte_i[7];
            nbits_q <= 4'd8;
            ph_q    <= 1'b0;
          end
        end else if (!ph_q) begin
          pclk_q <= 1'b1;
          ph_q   <= 1'b1;
        end else begin
          // falling edge of the data clock: next bit goes out together
          pclk_q  <= 1'b0;
          ph_q    <= 1'b0;
          sreg_q  <= {sreg_q[6:0], 1'b0};
          pdat_q  <= sreg_q[6];
          nbits_q <= nbits_q - 4'd1;
          dots_q  <= dots_q + 1'b1;
          if (dots_q == DOT_W'(LINE_DOTS - 1)) begin
            active_q <= 1'b0;
            done_q   <= 1'b1;
          end
        end
      end
    end
  end

  a_r3_pdat_stable_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_o |-> $stable(pdat_o));
  a_r3_pclk_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pclk_o |=> !pclk_o);
  a_r2_ready_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_ready_o |-> !pclk_o);
endmodule

// File: rtl/tph_strobe_seq.sv
module tph_strobe_seq #(
  parameter int GROUPS = 4,
  parameter int SW_W   = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              go_i,
  input  logic              pol_i,
  input  logic [SW_W-1:0]   width_i,
  output logic [GROUPS-1:0] strb_o,
  output logic              running_o,
  output logic              done_o
);
  localparam int GRP_W = (GROUPS > 1) ? $clog2(GROUPS) : 1;

  logic              running_q, done_q;
  logic [GRP_W-1:0]  grp_q;
  logic [SW_W-1:0]   cnt_q, w_eff;
  logic [GROUPS-1:0] act;

  assign w_eff     = (width_i == '0) ? SW_W'(1) : width_i;
  assign running_o = running_q;
  assign done_o    = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      running_q <= 1'b0;
      done_q    <= 1'b0;
      grp_q     <= '0;
      cnt_q     <= '0;
    end else begin
      done_q <= 1'b0;
      if (go_i && !running_q) begin
        running_q <= 1'b1;
        grp_q     <= '0;
        cnt_q     <= w_eff;
      end else if (running_q) begin
        if (cnt_q == SW_W'(1)) begin
          if (grp_q == GRP_W'(GROUPS - 1)) begin
            running_q <= 1'b0;
            done_q    <= 1'b1;
          end else begin
            grp_q <= grp_q + 1'b1;
            cnt_q <= w_eff;
          end
        end else begin
          cnt_q <= cnt_q - 1'b1;
        end
      end
    end
  end

  for (genvar g = 0; g < GROUPS; g++) begin : g_pin
    assign act[g]    = running_q && (grp_q == GRP_W'(g));
    assign strb_o[g] = pol_i ? act[g] : ~act[g];
  end

  a_r6_one_group: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(act));
  a_r5_ascending: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (act != '0 && $past(act) != '0 && act != $past(act)) |-> act == ($past(act) << 1));
  a_r9_done_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> act == '0);
endmodule

// File: rtl/tph_serial_if.sv
module tph_serial_if
  import tph_pkg::*;
#(
  parameter int LINE_DOTS = 1728,
  parameter int GROUPS    = 4,
  parameter int SW_W      = 16,
  parameter int LAT_CLKS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              strb_pol_i,
  input  logic [SW_W-1:0]   strb_width_i,
  input  logic [7:0]        byte_i,
  input  logic              byte_valid_i,
  output logic              byte_ready_o,
  output logic              pclk_o,
  output logic              pdat_o,
  output logic              plat_o,
  output logic [GROUPS-1:0] strb_o,
  output logic              busy_o,
  output logic              done_o
);
  localparam int LAT_W = $clog2(LAT_CLKS + 1);

  tph_state_e       state_q;
  logic [LAT_W-1:0] lat_cnt_q;
  logic             sh_go, sh_done, seq_go, seq_running, seq_done, lat_last;

  assign sh_go    = (state_q == ST_IDLE) && start_i;
  assign lat_last = (lat_cnt_q == LAT_W'(LAT_CLKS - 1));
  assign seq_go   = (state_q == ST_LATCH) && lat_last;
  assign plat_o   = (state_q == ST_LATCH);
  assign busy_o   = (state_q != ST_IDLE) || seq_running;
  assign done_o   = seq_done;

  tph_shift #(.LINE_DOTS(LINE_DOTS)) u_shift (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .go_i         (sh_go),
    .byte_i       (byte_i),
    .byte_valid_i (byte_valid_i),
    .byte_ready_o (byte_ready_o),
    .pclk_o       (pclk_o),
    .pdat_o       (pdat_o),
    .line_done_o  (sh_done)
  );

  tph_strobe_seq #(.GROUPS(GROUPS), .SW_W(SW_W)) u_seq (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .go_i      (seq_go),
    .pol_i     (strb_pol_i),
    .width_i   (strb_width_i),
    .strb_o    (strb_o),
    .running_o (seq_running),
    .done_o    (seq_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      lat_cnt_q <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE:  if (start_i) state_q <= ST_SHIFT;
        ST_SHIFT: if (sh_done) state_q <= ST_HOLD;
        ST_HOLD: begin
          // latch must not disturb the line that is still heating
          if (!seq_running) begin
            state_q   <= ST_LATCH;
            lat_cnt_q <= '0;
          end
        end
        ST_LATCH: begin
          if (lat_last) state_q <= ST_IDLE;
          else          lat_cnt_q <= lat_cnt_q + 1'b1;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  a_r4_latch_clock_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plat_o |-> !pclk_o);
  a_r8_latch_not_heating: assert property (@(posedge clk_i) disable iff (!rst_ni)
    plat_o |-> !seq_running);
  a_r9_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r9_busy_after_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && start_i) |=> busy_o);
  a_r10_start_no_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_SHIFT && start_i && !sh_done) |=> state_q == ST_SHIFT);
endmodule

// File: tb/tph_serial_if_bench.sv
module tph_serial_if_bench;
  localparam int DOTS = 16;
  localparam int GRP  = 4;
  localparam int SWW  = 8;
  localparam int LAT  = 3;

  logic           clk = 1'b0;
  logic           rst_ni = 1'b0;
  logic           start_i = 1'b0;
  logic           strb_pol_i = 1'b1;
  logic [SWW-1:0] strb_width_i = '0;
  logic [7:0]     byte_i = '0;
  logic           byte_valid_i = 1'b0;
  logic           byte_ready_o, pclk_o, pdat_o, plat_o, busy_o, done_o;
  logic [GRP-1:0] strb_o;

  always #2 clk = ~clk;

  tph_serial_if #(.LINE_DOTS(DOTS), .GROUPS(GRP), .SW_W(SWW), .LAT_CLKS(LAT)) u_tph_serial_if (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .strb_pol_i(strb_pol_i),
    .strb_width_i(strb_width_i), .byte_i(byte_i), .byte_valid_i(byte_valid_i),
    .byte_ready_o(byte_ready_o), .pclk_o(pclk_o), .pdat_o(pdat_o), .plat_o(plat_o),
    .strb_o(strb_o), .busy_o(busy_o), .done_o(done_o)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // monitor, sampled on the falling clock edge
  int cyc = 0, cap_n = 0, plat_n = 0, plat_len = 0, plat_rise = 0, plat_last = 0;
  int pfall = 0, err3 = 0, err4 = 0, err6 = 0, run_len = 0, slog_n = 0;
  int on_cyc = 0, off_cyc = 0, done_n = 0, done_cyc = 0;
  int slog_g [8];
  int slog_l [8];
  logic [DOTS-1:0] cap = '0;
  logic prev_pclk = 0, prev_pdat = 0, prev_plat = 0, prev_busy = 0;
  logic busy_at_done = 0, busy_before_done = 0;
  logic [GRP-1:0] prev_act = '0;

  function automatic int grp_idx(input logic [GRP-1:0] a);
    int r = -1;
    for (int i = 0; i < GRP; i++) if (a[i]) r = i;
    return r;
  endfunction

  always @(negedge clk) begin
    logic [GRP-1:0] act;
    if (rst_ni) begin
      cyc++;
      act = strb_pol_i ? strb_o : ~strb_o;
      if (pclk_o && !prev_pclk) begin cap = {cap[DOTS-2:0], pdat_o}; cap_n++; end
      if (!pclk_o && prev_pclk) pfall = cyc;
      if (pclk_o && prev_pclk) err3++;
      if (pclk_o && pdat_o != prev_pdat) err3++;
      if (plat_o && !prev_plat) begin plat_n++; plat_rise = cyc; plat_len = 0; slog_n = 0; end
      if (plat_o) begin plat_len++; plat_last = cyc; if (pclk_o) err4++; end
      if ($countones(act) > 1) err6++;
      if (act != prev_act) begin
        if (prev_act != '0 && slog_n < 8) begin
          slog_g[slog_n] = grp_idx(prev_act);
          slog_l[slog_n] = run_len;
          slog_n++;
        end
        if (prev_act == '0) on_cyc = cyc;
        if (act == '0) off_cyc = cyc;
        run_len = 1;
      end else run_len++;
      if (done_o) begin
        done_n++; done_cyc = cyc; busy_at_done = busy_o; busy_before_done = prev_busy;
      end
      prev_pclk = pclk_o; prev_pdat = pdat_o; prev_plat = plat_o;
      prev_busy = busy_o; prev_act = act;
    end
  end

  task automatic req_line();
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(busy_o == 1'b1, "R9 busy after start", busy_o, 1);
  endtask

  task automatic send_bytes(input logic [7:0] b0, input logic [7:0] b1, input bit ign);
    for (int i = 0; i < 2; i++) begin
      @(negedge clk);
      byte_i = (i == 0) ? b0 : b1;
      byte_valid_i = 1'b1;
      start_i = ign && (i == 1);
      while (!byte_ready_o) begin @(negedge clk); start_i = 1'b0; end
    end
    @(negedge clk);
    byte_valid_i = 1'b0;
    start_i = 1'b0;
  endtask

  task automatic wait_done(input int target);
    while (done_n < target) @(posedge clk);
  endtask

  task automatic check_strobes(input int weff, input string tag);
    chk(slog_n == GRP, {tag, " R5 group count"}, slog_n, GRP);
    for (int i = 0; i < GRP; i++) begin
      chk(slog_g[i] == i, {tag, " R5 group order"}, slog_g[i], i);
      chk(slog_l[i] == weff, {tag, " R5 group width"}, slog_l[i], weff);
    end
    chk(on_cyc == plat_last + 1, {tag, " R5 first strobe after latch"}, on_cyc, plat_last + 1);
  endtask

  task automatic do_line(input logic [7:0] b0, input logic [7:0] b1, input logic pol,
                         input int w, input bit ign);
    int c0, p0, d0, weff;
    weff = (w == 0) ? 1 : w;
    @(negedge clk);
    strb_pol_i = pol;
    strb_width_i = SWW'(w);
    @(posedge clk);
    c0 = cap_n; p0 = plat_n; d0 = done_n;
    req_line();
    send_bytes(b0, b1, ign);
    wait_done(d0 + 1);
    repeat (3) @(posedge clk);
    chk(cap_n - c0 == DOTS, "R2 rising data clocks per line", cap_n - c0, DOTS);
    chk(cap == {b0, b1}, "R2 bit order msb first", int'(cap), int'({b0, b1}));
    chk(plat_n - p0 == 1, ign ? "R10 one latch despite extra start" : "R4 one latch",
        plat_n - p0, 1);
    chk(plat_len == LAT, "R4 latch length", plat_len, LAT);
    chk(plat_rise == pfall + 2, "R4 latch after last clock", plat_rise, pfall + 2);
    check_strobes(weff, pol ? "R7 pol1" : "R7 pol0");
    chk(done_n - d0 == 1, "R9 single done", done_n - d0, 1);
    chk(done_cyc == off_cyc, "R9 done at strobe end", done_cyc, off_cyc);
    chk(!busy_at_done && busy_before_done, "R9 busy drops with done",
        {busy_before_done, busy_at_done}, 2);
    chk(strb_o == (pol ? 4'h0 : 4'hF), "R7 idle strobe level", strb_o, pol ? 0 : 15);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int off1, d0, p0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({pclk_o, plat_o, busy_o, done_o, byte_ready_o} == 5'b0, "R1 idle pins",
        {pclk_o, plat_o, busy_o, done_o, byte_ready_o}, 0);
    chk(strb_o == 4'h0, "R1 strobes inactive pol1", strb_o, 0);
    strb_pol_i = 1'b0;
    #1;
    chk(strb_o == 4'hF, "R7 strobes inactive pol0", strb_o, 15);
    @(negedge clk) rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    do_line(8'hA5, 8'h3C, 1'b1, 3, 1'b0);
    do_line(8'hFF, 8'h00, 1'b0, 1, 1'b0);
    do_line(8'h80, 8'h01, 1'b1, 0, 1'b0);
    do_line(8'h5A, 8'hC3, 1'b1, 2, 1'b1);   // R10 extra start mid-shift

    // sweep of widths and polarities
    for (int w = 0; w < 6; w++) begin
      for (int p = 0; p < 2; p++) begin
        logic [7:0] a;
        a = 8'(w * 37 + p * 91 + 5);
        do_line(a, ~a ^ 8'(w), p[0], w, 1'b0);
      end
    end

    // R8 overlap: second line shifts while the first heats
    @(negedge clk);
    strb_pol_i = 1'b1;
    strb_width_i = SWW'(20);
    @(posedge clk);
    d0 = done_n;
    req_line();
    send_bytes(8'h12, 8'h34, 1'b0);
    while (!plat_o) @(negedge clk);
    while (plat_o) @(negedge clk);
    @(posedge clk);
    p0 = plat_n;
    req_line();
    send_bytes(8'hE7, 8'h18, 1'b0);
    wait_done(d0 + 1);
    off1 = off_cyc;
    chk(busy_at_done == 1'b1, "R9 busy held by pending line", busy_at_done, 1);
    chk(plat_n == p0, "R8 no latch during heating", plat_n, p0);
    wait_done(d0 + 2);
    repeat (3) @(posedge clk);
    chk(plat_rise == off1 + 1, "R8 latch after previous strobes", plat_rise, off1 + 1);
    chk(cap == 16'hE718, "R8 second line data", int'(cap), 16'hE718);
    check_strobes(20, "R8 second line");

    chk(err3 == 0, "R3 data clock and data timing", err3, 0);
    chk(err4 == 0, "R4 data clock low during latch", err4, 0);
    chk(err6 == 0, "R6 single active group", err6, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule